// File: doc/BRIEF.md
# Hot-Plug Slot Event Interrupt Aggregator

This block gathers the asynchronous status signals of a set of hot-plug slots (card presence, attention button, retention latch, isolated and connected power faults) and turns their transitions into sticky event flags. The flags are kept per slot in a 32-bit slot register, together with per-event interrupt masks and two error-report masks. A controller register holds global interrupt and error masks, plus two sticky detect flags for command completion and bus arbiter errors, which arrive as pulses from neighbouring logic.

Software reads a pending-source vector to see which slot needs service. It reads that slot's register and writes the same value back, which clears exactly the events it saw. All slot inputs pass through a synchronizer before edge detection. The block drives one interrupt line and one system-error line. Each line is gated by its own global mask.

Address map (word index on `addr`): 0 is the pending-source vector (read only), 1 is the controller register, and 2+i is the register of slot i. Any other address reads zero.

Top module: `hp_evt_agg`

## Requirements
- R1: After reset, all event and detect flags are 0, all mask bits are 1, `irq_o` and `serr_o` are 0, and the controller register reads 0x0000000F.
- R2: Any change of a slot's 2-bit presence input sets event bit 16, and a change of its latch input in either direction sets event bit 19.
- R3: A 0-to-1 transition of the button input sets event bit 18. Release sets nothing.
- R4: A rising isolated-fault input sets bit 17, and a rising connected-fault input sets bit 20. Slot bit 6 reads 0 while either fault input is high.
- R5: A slot event bit clears only when a write to that slot register carries 1 in that bit. Writing 0 leaves it set, so writing back a read value clears exactly the events that were read.
- R6: When an event is detected in the same cycle as a write that clears that bit, the bit stays set.
- R7: Slot register bits 31, 23:21, 15:12, 9 and 5:0 read 0 even after writing all ones. Controller bits 31:18 and 15:4 read 0.
- R8: Pending-source bit i+1 is set when slot i has any event bit (16+k) whose interrupt mask bit (24+k) is 0. Bit 0 is set when the command detect flag (controller bit 16) is set and the command mask (controller bit 2) is 0.
- R9: `irq_o` is 1 exactly when some pending-source bit is set and the global interrupt mask (controller bit 0) is 0.
- R10: `serr_o` is 1 when the global error mask (controller bit 1) is 0 and at least one of these holds: a slot has latch event with bit 29 clear; a slot has connected-fault event with bit 30 clear; the arbiter detect flag (bit 17) is set with bit 3 clear.
- R11: A `cmd_done_i` pulse sets controller bit 16, and an `arb_err_i` pulse sets controller bit 17. Both flags clear on a write of 1.
- R12: Slot mask bits 30:24 and controller mask bits 3:0 take the written value and read back unchanged.
- R13: Slot register live bits show the synchronized inputs: bits 11:10 presence (3 means empty), bit 8 latch open, bit 7 button held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | $clog2(NSLOT+2) | Register word index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| prsnt_i | input | 2*NSLOT | Presence code per slot, 2 bits each, 3 is empty |
| btn_i | input | NSLOT | Attention button held, per slot |
| latch_i | input | NSLOT | Retention latch open, per slot |
| iso_flt_i | input | NSLOT | Isolated power fault, per slot |
| con_flt_i | input | NSLOT | Connected power fault, per slot |
| cmd_done_i | input | 1 | Command completion pulse |
| arb_err_i | input | 1 | Arbiter error pulse |
| irq_o | output | 1 | Interrupt request |
| serr_o | output | 1 | System error request |

## Verification
The bench builds the block with NSLOT = 3 and SYNC = 2. Three slots are few enough to sweep every event kind on every slot, in both input directions, and to confirm that the pending-source bit lands at i+1. The two-stage synchronizer puts event detection exactly three edges after an input change. That fixed latency lets the bench place a clearing write on the very edge where a new event arrives. Each interrupt and error mask is also swept one bit at a time.

// File: rtl/hp_evt_agg.sv
module hp_evt_agg #(
  parameter int NSLOT = 4,
  parameter int SYNC  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(NSLOT+2)-1:0] addr,
  input  logic [31:0]                wdata,
  output logic [31:0]                rdata,
  input  logic [2*NSLOT-1:0]         prsnt_i,
  input  logic [NSLOT-1:0]           btn_i,
  input  logic [NSLOT-1:0]           latch_i,
  input  logic [NSLOT-1:0]           iso_flt_i,
  input  logic [NSLOT-1:0]           con_flt_i,
  input  logic                       cmd_done_i,
  input  logic                       arb_err_i,
  output logic                       irq_o,
  output logic                       serr_o
);
  localparam int AW = $clog2(NSLOT+2);
  localparam int SW = 6*NSLOT;
  localparam logic [5:0] IDLE = 6'b000011;

  logic [SW-1:0]      raw;
  logic [SW-1:0]      sync_q [SYNC];
  logic [SW-1:0]      prev_q;
  logic [SW-1:0]      cur;
  logic [5*NSLOT-1:0] evt_q;
  logic [NSLOT-1:0]   pend, sreq;
  logic [31:0]        slot_rd [NSLOT];
  logic [3:0]         cmask_q;
  logic [1:0]         cdet_q;
  logic [NSLOT:0]     loc;
  logic               csel;

  assign cur = sync_q[SYNC-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SYNC; k++) sync_q[k] <= {NSLOT{IDLE}};
      prev_q <= {NSLOT{IDLE}};
    end else begin
      sync_q[0] <= raw;
      for (int k = 1; k < SYNC; k++) sync_q[k] <= sync_q[k-1];
      prev_q <= cur;
    end
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic [5:0] now, old;
    logic [4:0] evt, set, clr;
    logic [6:0] msk;
    logic       sel;

    assign raw[6*i +: 6] = {con_flt_i[i], iso_flt_i[i], latch_i[i], btn_i[i], prsnt_i[2*i +: 2]};
    assign now = cur[6*i +: 6];
    assign old = prev_q[6*i +: 6];
    assign sel = wr_en && (addr == AW'(i+2));

    assign set[0] = now[1:0] != old[1:0];
    assign set[1] = now[4] & ~old[4];
    assign set[2] = now[2] & ~old[2];
    assign set[3] = now[3] ^ old[3];
    assign set[4] = now[5] & ~old[5];
    assign clr    = sel ? wdata[20:16] : 5'b0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        evt <= '0;
        msk <= '1;
      end else begin
        evt <= (evt & ~clr) | set;
        if (sel) msk <= wdata[30:24];
      end
    end

    assign evt_q[5*i +: 5] = evt;
    assign pend[i] = |(evt & ~msk[4:0]);
    assign sreq[i] = (evt[3] & ~msk[5]) | (evt[4] & ~msk[6]);
    assign slot_rd[i] = {1'b0, msk, 3'b0, evt, 4'b0, now[1:0], 1'b0,
                         now[3], now[2], ~(now[4] | now[5]), 6'b0};
  end

  assign csel = wr_en && (addr == AW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmask_q <= '1;
      cdet_q  <= '0;
    end else begin
      cdet_q <= (cdet_q & ~(csel ? wdata[17:16] : 2'b0)) | {arb_err_i, cmd_done_i};
      if (csel) cmask_q <= wdata[3:0];
    end
  end

  assign loc    = {pend, cdet_q[0] & ~cmask_q[2]};
  assign irq_o  = (|loc) & ~cmask_q[0];
  assign serr_o = ~cmask_q[1] & ((|sreq) | (cdet_q[1] & ~cmask_q[3]));

  always_comb begin
    rdata = '0;
    if (addr == AW'(0)) rdata[NSLOT:0] = loc;
    else if (addr == AW'(1)) rdata = {14'b0, cdet_q, 12'b0, cmask_q};
    else
      for (int i = 0; i < NSLOT; i++)
        if (addr == AW'(i+2)) rdata = slot_rd[i];
  end
endmodule

module hp_evt_agg_chk #(
  parameter int NSLOT = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_en,
  input logic [$clog2(NSLOT+2)-1:0] addr,
  input logic [31:0]                wdata,
  input logic [31:0]                rdata,
  input logic                       irq_o,
  input logic                       serr_o,
  input logic                       cmd_done_i,
  input logic [5*NSLOT-1:0]         evt_q,
  input logic [3:0]                 cmask_q,
  input logic [1:0]                 cdet_q
);
  localparam int AW = $clog2(NSLOT+2);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (evt_q == '0 && cmask_q == 4'hF && cdet_q == 2'b0 && !irq_o && !serr_o));

  for (genvar s = 0; s < NSLOT; s++) begin : g_s
    for (genvar k = 0; k < 5; k++) begin : g_k
      // R5
      evt_clear_only_by_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(evt_q[5*s+k]) |-> $past(wr_en && addr == AW'(s+2) && wdata[16+k]));
    end
  end

  // R11
  cmd_detect_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done_i |=> cdet_q[0]);

  // R9
  irq_global_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (!cmask_q[0] && ((|evt_q) || cdet_q[0])));

  // R10
  serr_global_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    serr_o |-> (!cmask_q[1] && ((|evt_q) || cdet_q[1])));

  // R7
  slot_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(addr) >= 2 && int'(addr) < NSLOT+2) |-> (rdata[31] == 1'b0 && rdata[23:21] == 3'b0 && rdata[15] == 1'b0));

  // R7
  ctrl_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(1)) |-> (rdata[31:18] == 14'b0 && rdata[15:4] == 12'b0));
endmodule

bind hp_evt_agg hp_evt_agg_chk #(.NSLOT(NSLOT)) u_chk (.*);

// File: tb/hp_evt_agg_bench.sv
module hp_evt_agg_bench;
  localparam int N  = 3;
  localparam int AW = $clog2(N+2);

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [2*N-1:0] prsnt = '1;
  logic [N-1:0] btn = '0, latch = '0, iso = '0, con = '0;
  logic cmd_done = 0, arb_err = 0, irq, serr;
  int checks = 0, errors = 0;
  logic [31:0] v;

  always #5 clk = ~clk;

  hp_evt_agg #(.NSLOT(N), .SYNC(2)) u_hp_evt_agg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .prsnt_i(prsnt), .btn_i(btn), .latch_i(latch), .iso_flt_i(iso), .con_flt_i(con),
    .cmd_done_i(cmd_done), .arb_err_i(arb_err), .irq_o(irq), .serr_o(serr));

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); addr = AW'(a); wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk); wr_en = 0; addr = AW'(a); #1 d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [31:0] live(int s);
    logic [31:0] r = '0;
    r[11:10] = prsnt[2*s +: 2];
    r[8] = latch[s];
    r[7] = btn[s];
    r[6] = ~(iso[s] | con[s]);
    return r;
  endfunction

  function automatic logic [31:0] slotv(int s, logic [4:0] e, logic [6:0] m);
    return {1'b0, m, 3'b0, e, 16'b0} | live(s);
  endfunction

  task automatic drive(int s, int e, logic on);
    case (e)
      0: prsnt[2*s +: 2] = on ? 2'b10 : 2'b11;
      1: iso[s] = on;
      2: btn[s] = on;
      3: latch[s] = on;
      default: con[s] = on;
    endcase
  endtask

  task automatic pulse(int which);
    @(negedge clk);
    if (which == 0) cmd_done = 1; else arb_err = 1;
    @(negedge clk);
    cmd_done = 0; arb_err = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(1, v); chk("R1 ctrl", v, 32'h0000_000F);
    rd(0, v); chk("R1 locator", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 serr", {31'b0, serr}, 0);
    for (int s = 0; s < N; s++) begin
      rd(2+s, v); chk("R1 slot", v, slotv(s, 5'b0, 7'h7F));
    end

    // R12 mask round trip
    wr(1, 0); rd(1, v); chk("R12 ctrl", v, 0);
    for (int s = 0; s < N; s++) begin
      wr(2+s, 32'h6000_0000); rd(2+s, v); chk("R12 slot mask", v, slotv(s, 5'b0, 7'h60));
    end

    // R2 R3 R4 R8 R9 R13 sweep of every event on every slot, both directions
    for (int s = 0; s < N; s++) begin
      for (int e = 0; e < 5; e++) begin
        drive(s, e, 1); settle();
        rd(2+s, v); chk("R2/R3/R4/R13 event set", v, slotv(s, 5'(1 << e), 7'h60));
        rd(0, v); chk("R8 locator", v, 32'(1 << (s+1)));
        chk("R9 irq", {31'b0, irq}, 1);
        rd(2+s, v); wr(2+s, v);
        rd(2+s, v); chk("R5 write-back clear", v, slotv(s, 5'b0, 7'h60));
        chk("R9 irq low", {31'b0, irq}, 0);
        drive(s, e, 0); settle();
        rd(2+s, v);
        chk("R2/R3/R4 release", v, slotv(s, (e == 0 || e == 3) ? 5'(1 << e) : 5'b0, 7'h60));
        wr(2+s, 32'h601F_0000);
      end
    end

    // R8 per-event interrupt masks
    for (int e = 0; e < 5; e++) begin
      wr(3, 32'h6000_0000 | (32'h1 << (24+e)));
      drive(1, e, 1); settle();
      rd(0, v); chk("R8 masked event", v, 0);
      rd(3, v); chk("R8 event still latched", v[20:16], 32'(1 << e));
      drive(1, e, 0); settle();
      wr(3, 32'h601F_0000);
    end
    wr(3, 32'h6000_0000);

    // R9 global interrupt mask
    drive(2, 2, 1); settle();
    wr(1, 1);
    chk("R9 gmask irq", {31'b0, irq}, 0);
    rd(0, v); chk("R9 locator under gmask", v, 32'h8);
    wr(1, 0);
    chk("R9 unmask irq", {31'b0, irq}, 1);
    drive(2, 2, 0); wr(4, 32'h6004_0000);

    // R10 error line
    wr(2, 32'h4000_0000);
    drive(0, 3, 1); settle();
    chk("R10 latch serr", {31'b0, serr}, 1);
    wr(1, 2);
    chk("R10 gserr mask", {31'b0, serr}, 0);
    wr(1, 0);
    drive(0, 3, 0); settle(); wr(2, 32'h4008_0000);
    chk("R10 serr cleared", {31'b0, serr}, 0);
    wr(2, 32'h2000_0000);
    drive(0, 4, 1); settle();
    chk("R10 confault serr", {31'b0, serr}, 1);
    drive(0, 4, 0); settle(); wr(2, 32'h2010_0000);
    chk("R10 confault cleared", {31'b0, serr}, 0);
    wr(2, 32'h6000_0000);

    // R11 command and arbiter detects
    pulse(0);
    rd(1, v); chk("R11 cmd detect", v, 32'h0001_0000);
    rd(0, v); chk("R8 cmd locator bit0", v, 1);
    chk("R9 cmd irq", {31'b0, irq}, 1);
    wr(1, 32'h0001_0000); rd(1, v); chk("R11 cmd clear", v, 0);
    wr(1, 4); pulse(0);
    rd(0, v); chk("R8 cmd masked", v, 0);
    rd(1, v); chk("R11 cmd masked latched", v, 32'h0001_0004);
    wr(1, 32'h0001_0000);
    pulse(1);
    rd(1, v); chk("R11 arb detect", v, 32'h0002_0000);
    chk("R10 arb serr", {31'b0, serr}, 1);
    wr(1, 32'h0002_0000);
    chk("R10 arb cleared", {31'b0, serr}, 0);

    // R5 writing zero keeps events
    drive(0, 2, 1); settle();
    wr(2, 32'h6000_0000);
    rd(2, v); chk("R5 zero write keeps", v, slotv(0, 5'b00100, 7'h60));
    drive(0, 2, 0); wr(2, 32'h6004_0000);

    // R6 set wins over clear
    latch[1] = 1; settle();
    @(negedge clk); latch[1] = 0;
    @(negedge clk);
    @(negedge clk); addr = AW'(3); wdata = 32'h6008_0000; wr_en = 1;
    @(negedge clk); wr_en = 0;
    rd(3, v); chk("R6 set wins", v, slotv(1, 5'b01000, 7'h60));
    wr(3, 32'h6008_0000);
    rd(3, v); chk("R6 then clears", v, slotv(1, 5'b0, 7'h60));

    // R7 reserved bits
    wr(2, 32'hFFFF_FFFF);
    rd(2, v); chk("R7 slot reserved", v, slotv(0, 5'b0, 7'h7F));
    wr(1, 32'hFFFF_FFFF);
    rd(1, v); chk("R7 ctrl reserved", v, 32'h0000_000F);
    rd(7, v); chk("R7 unmapped", v, 0);

    finish_run();
  end
endmodule